// File: doc/BRIEF.md
# DMA Page Register and Physical Address Former

This block keeps the page bytes for a four-channel DMA controller and turns them into the physical bus address for the channel that is currently being serviced. Each channel owns a low page byte and a high page byte. Both banks are reached through a byte-wide register port. A 3-bit port index is decoded into a channel number through a fixed, sparse table, and indices outside that table have no effect on the page bytes.

When a request is strobed, the block builds a 31-bit physical address. Bits [30:24] come from the low seven bits of the high page, bits [23:16] from the low page, and bits [15:0] from the 16-bit current address supplied by the channel logic. It then applies a block offset and a block length. In increment mode the block starts at the composed address plus the offset. In decrement mode (bit 5 of the channel mode byte set) the block starts below the current address, at the composed address minus the offset minus the length. In that case a reverse-order flag tells the data path to deliver the bytes of the block last-first.

The high page bank can be switched off by a configuration input. While it is off, its ports neither store nor return data. The high page bytes already held keep feeding the address.

Top module: `dma_page_addr_gen`

## Requirements
- R1: Port index bits [2:0] map to channels as follows: index 3 selects channel 1, index 1 selects channel 2, index 2 selects channel 3, and index 7 selects channel 0. The mapping is the same for both banks (reg_bank 0 = low page, 1 = high page).
- R2: A write (reg_sel=1, reg_we=1) to index 0, 4, 5 or 6 changes no page byte in either bank.
- R3: While reg_sel is 1 and the index is 0, 4, 5 or 6, reg_rdata is 0.
- R4: A read (reg_sel=1, reg_we=0) of a valid index returns the byte last written to that channel's page in the selected bank. reg_rdata is combinational.
- R5: The address is {high_page[6:0], low_page[7:0], req_cur_addr[15:0]} for the channel on req_chan. Bit 7 of the high page never reaches the address.
- R6: When req_mode bit 5 is 0, addr_out equals the composed address plus req_pos, modulo 2^31, and addr_rev is 0.
- R7: When req_mode bit 5 is 1, addr_out equals the composed address minus req_pos minus req_len, modulo 2^31, and addr_rev is 1.
- R8: While hi_en is 0, writes to the high bank are ignored and reads of it return 0. Bytes written earlier become readable again once hi_en returns to 1.
- R9: addr_valid is 1 exactly in the cycle after a cycle with req=1. addr_out and addr_rev are registered on that edge and hold their values while req is 0.
- R10: After reset, every page byte in both banks is 0, and addr_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_en | input | 1 | Enables the high page bank ports |
| reg_sel | input | 1 | Register port access strobe |
| reg_we | input | 1 | Write enable for the register port |
| reg_bank | input | 1 | 0 selects the low page bank, 1 the high page bank |
| reg_idx | input | 3 | Page port index |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data byte (combinational) |
| req | input | 1 | Address request strobe |
| req_chan | input | 2 | Channel being serviced |
| req_cur_addr | input | 16 | Current 16-bit address of that channel |
| req_mode | input | 8 | Channel mode byte; bit 5 selects decrement |
| req_pos | input | 16 | Offset of the block within the transfer |
| req_len | input | 16 | Length of the block |
| addr_valid | output | 1 | Address result valid |
| addr_out | output | 31 | Physical start address of the block |
| addr_rev | output | 1 | Bytes of the block are delivered in reverse order |

## Verification
Read data is combinational, so each read is checked one time unit after its inputs settle on the falling edge, in the same cycle. Page writes take effect at the next rising edge, and the bench applies them to its own model only then. A request placed on the falling edge is captured at the next rising edge, so addr_out, addr_rev and addr_valid are compared at the falling edge that follows it. At the falling edge after that, the bench checks that addr_valid has dropped and that the address has held its value.

// File: rtl/dma_page_addr_gen.sv
module dma_page_addr_gen #(
  parameter int CH_W    = 2,
  parameter int PG_W    = 8,
  parameter int HI_USED = 7,
  parameter int ADDR_W  = 16,
  parameter int OFS_W   = 16,
  parameter int MODE_W  = 8,
  parameter int DEC_BIT = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hi_en,
  input  logic                 reg_sel,
  input  logic                 reg_we,
  input  logic                 reg_bank,
  input  logic [2:0]           reg_idx,
  input  logic [PG_W-1:0]      reg_wdata,
  output logic [PG_W-1:0]      reg_rdata,
  input  logic                 req,
  input  logic [CH_W-1:0]      req_chan,
  input  logic [ADDR_W-1:0]    req_cur_addr,
  input  logic [MODE_W-1:0]    req_mode,
  input  logic [OFS_W-1:0]     req_pos,
  input  logic [OFS_W-1:0]     req_len,
  output logic                 addr_valid,
  output logic [HI_USED+PG_W+ADDR_W-1:0] addr_out,
  output logic                 addr_rev
);
  localparam int NCH    = 1 << CH_W;
  localparam int PHYS_W = HI_USED + PG_W + ADDR_W;

  logic [NCH-1:0][PG_W-1:0] lo_q, hi_q;
  logic                     map_ok;
  logic [CH_W-1:0]          map_ch;
  logic                     wr_hit;
  logic [PHYS_W-1:0]        base, up_addr, dn_addr;

  always_comb begin
    map_ok = 1'b1;
    map_ch = '0;
    case (reg_idx)
      3'd1:    map_ch = CH_W'(2);
      3'd2:    map_ch = CH_W'(3);
      3'd3:    map_ch = CH_W'(1);
      3'd7:    map_ch = CH_W'(0);
      default: map_ok = 1'b0;
    endcase
  end

  assign wr_hit = reg_sel && reg_we && map_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (wr_hit) begin
      if (!reg_bank)
        lo_q[map_ch] <= reg_wdata;
      else if (hi_en)
        hi_q[map_ch] <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_sel && map_ok) begin
      if (!reg_bank)
        reg_rdata = lo_q[map_ch];
      else if (hi_en)
        reg_rdata = hi_q[map_ch];
    end
  end

  assign base    = {hi_q[req_chan][HI_USED-1:0], lo_q[req_chan], req_cur_addr};
  assign up_addr = base + PHYS_W'(req_pos);
  assign dn_addr = base - PHYS_W'(req_pos) - PHYS_W'(req_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_valid <= 1'b0;
      addr_out   <= '0;
      addr_rev   <= 1'b0;
    end else begin
      addr_valid <= req;
      if (req) begin
        addr_out <= req_mode[DEC_BIT] ? dn_addr : up_addr;
        addr_rev <= req_mode[DEC_BIT];
      end
    end
  end

  // R2
  inv_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel && reg_we && !map_ok |=> $stable(lo_q) && $stable(hi_q));

  // R3
  inv_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel && !map_ok |-> reg_rdata == '0);

  // R8
  hi_disabled_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel && reg_we && reg_bank && !hi_en |=> $stable(hi_q));

  // R9
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> addr_valid);

  // R9
  valid_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !addr_valid && $stable(addr_out));

  // R7
  rev_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> addr_rev == $past(req_mode[DEC_BIT]));
endmodule

// File: tb/dma_page_addr_gen_tb.sv
module dma_page_addr_gen_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        hi_en = 1;
  logic        reg_sel = 0, reg_we = 0, reg_bank = 0;
  logic [2:0]  reg_idx = 0;
  logic [7:0]  reg_wdata = 0;
  logic [7:0]  reg_rdata;
  logic        req = 0;
  logic [1:0]  req_chan = 0;
  logic [15:0] req_cur_addr = 0;
  logic [7:0]  req_mode = 0;
  logic [15:0] req_pos = 0, req_len = 0;
  logic        addr_valid;
  logic [30:0] addr_out;
  logic        addr_rev;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] lo_m [4];
  logic [7:0] hi_m [4];

  always #2 clk = ~clk;

  dma_page_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .hi_en(hi_en),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_bank(reg_bank),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req(req), .req_chan(req_chan), .req_cur_addr(req_cur_addr),
    .req_mode(req_mode), .req_pos(req_pos), .req_len(req_len),
    .addr_valid(addr_valid), .addr_out(addr_out), .addr_rev(addr_rev));

  function automatic int idx2ch(input logic [2:0] idx);
    case (idx)
      3'd3: return 1;
      3'd1: return 2;
      3'd2: return 3;
      3'd7: return 0;
      default: return -1;
    endcase
  endfunction

  function automatic logic [30:0] exp_addr(input int ch, input logic [15:0] cur,
      input logic dec, input logic [15:0] pos, input logic [15:0] len);
    logic [31:0] b;
    b = {1'b0, hi_m[ch][6:0], lo_m[ch], cur};
    if (dec) b = b - {16'd0, pos} - {16'd0, len};
    else     b = b + {16'd0, pos};
    return b[30:0];
  endfunction

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic do_write(input logic bank, input logic [2:0] idx, input logic [7:0] d);
    int ch;
    @(negedge clk);
    reg_sel = 1; reg_we = 1; reg_bank = bank; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_sel = 0; reg_we = 0;
    ch = idx2ch(idx);
    if (ch >= 0) begin
      if (!bank) lo_m[ch] = d;
      else if (hi_en) hi_m[ch] = d;
    end
  endtask

  task automatic do_read(input logic bank, input logic [2:0] idx, input string r);
    int ch;
    logic [7:0] e;
    @(negedge clk);
    reg_sel = 1; reg_we = 0; reg_bank = bank; reg_idx = idx;
    #1;
    ch = idx2ch(idx);
    if (ch < 0) e = 0;
    else if (bank) e = hi_en ? hi_m[ch] : 8'd0;
    else e = lo_m[ch];
    chk(reg_rdata == e, r, 32'(reg_rdata), 32'(e));
    reg_sel = 0;
  endtask

  task automatic do_req(input logic [1:0] ch, input logic [15:0] cur, input logic [7:0] mode,
      input logic [15:0] pos, input logic [15:0] len, input string r);
    logic [30:0] e;
    @(negedge clk);
    req = 1; req_chan = ch; req_cur_addr = cur; req_mode = mode; req_pos = pos; req_len = len;
    e = exp_addr(int'(ch), cur, mode[5], pos, len);
    @(negedge clk);
    req = 0;
    chk(addr_valid == 1'b1, {r, " valid"}, 32'(addr_valid), 32'd1);
    chk(addr_out == e, {r, " addr"}, 32'(addr_out), 32'(e));
    chk(addr_rev == mode[5], {r, " rev"}, 32'(addr_rev), 32'(mode[5]));
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin lo_m[i] = 0; hi_m[i] = 0; end
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    #1;
    chk(addr_valid == 0, "R10 valid", 32'(addr_valid), 0);
    for (int i = 0; i < 8; i++) begin
      do_read(0, 3'(i), "R10 low");
      do_read(1, 3'(i), "R10 high");
    end
    do_req(2'd2, 16'h1234, 8'h00, 0, 0, "R10 addr");

    // R1 mapping via distinct bytes
    do_write(0, 3'd7, 8'hA0); do_write(0, 3'd3, 8'hA1);
    do_write(0, 3'd1, 8'hA2); do_write(0, 3'd2, 8'hA3);
    do_write(1, 3'd7, 8'h10); do_write(1, 3'd3, 8'h11);
    do_write(1, 3'd1, 8'h12); do_write(1, 3'd2, 8'h13);
    for (int c = 0; c < 4; c++) do_req(2'(c), 16'h0000, 8'h00, 0, 0, "R1 map");
    do_read(0, 3'd3, "R4 low"); do_read(1, 3'd2, "R4 high");

    // R2 invalid writes
    foreach (lo_m[i]) ;
    do_write(0, 3'd0, 8'hFF); do_write(0, 3'd4, 8'hFF);
    do_write(1, 3'd5, 8'hFF); do_write(1, 3'd6, 8'hFF);
    for (int c = 0; c < 4; c++) do_req(2'(c), 16'h5555, 8'h00, 0, 0, "R2 ignored");
    // R3 invalid reads
    do_read(0, 3'd4, "R3"); do_read(1, 3'd6, "R3");

    // R5 high bit 7 dropped
    do_write(1, 3'd3, 8'hFF); do_write(0, 3'd3, 8'h00);
    do_req(2'd1, 16'hFFFF, 8'h00, 0, 0, "R5");
    chk(addr_out == 31'h7F00FFFF, "R5 top", 32'(addr_out), 32'h7F00FFFF);

    // R6 up and R7 down / wrap
    do_req(2'd1, 16'hFFFF, 8'h00, 16'h0001, 16'h0040, "R6 carry");
    do_write(1, 3'd7, 8'h00); do_write(0, 3'd7, 8'h00);
    do_req(2'd0, 16'h0000, 8'h20, 16'h0001, 16'h0001, "R7 wrap");
    chk(addr_out == 31'h7FFFFFFE, "R7 wrap value", 32'(addr_out), 32'h7FFFFFFE);
    do_req(2'd2, 16'h8000, 8'h20, 16'h0100, 16'h0010, "R7 down");

    // R9 hold after request
    @(negedge clk);
    chk(addr_valid == 0, "R9 drop", 32'(addr_valid), 0);
    chk(addr_out == exp_addr(2, 16'h8000, 1, 16'h0100, 16'h0010), "R9 hold",
        32'(addr_out), 32'(exp_addr(2, 16'h8000, 1, 16'h0100, 16'h0010)));

    // R8 high bank disable
    do_write(1, 3'd1, 8'h5A);
    hi_en = 0;
    do_write(1, 3'd1, 8'hC3);
    do_read(1, 3'd1, "R8 read off");
    do_req(2'd2, 16'h0000, 8'h00, 0, 0, "R8 addr off");
    hi_en = 1;
    do_read(1, 3'd1, "R8 read on");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int k;
      k = $urandom_range(0, 2);
      if (k == 0) do_write(1'($urandom), 3'($urandom), 8'($urandom));
      else if (k == 1) do_read(1'($urandom), 3'($urandom), "R4 rnd");
      else do_req(2'($urandom), 16'($urandom), 8'($urandom), 16'($urandom), 16'($urandom), "R6/R7 rnd");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule